// File: doc/BRIEF.md
# Bus Request and Grant Arbiter

This block sits next to a processor's bus cycle engine and handles the processor's side of a two-wire bus ownership handshake. Any number of other would-be masters share one active-low request line, which is wired-OR at the board level. Whoever pulls that line low asks the processor to hand over the bus. The arbiter answers on an active-low grant line. The grant means that the processor will let go of the address, data and control lines at the end of the bus cycle now running. If no cycle is running, the processor lets go at once.

A request may arrive at any moment, including in the middle of a transfer or while the engine is idle. The arbiter first passes the request through a chain of synchronizer flops. Once the request is seen, the arbiter raises a stall to the cycle engine so that no new cycle starts. If a cycle is in flight, the arbiter waits for that cycle's last clock. It then drops the driver enable, which tri-states the processor's bus drivers. When the requester lets go of the request line, the grant is removed first. The processor re-enables its drivers one clock later and resumes issuing cycles.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While reset is asserted, and right after it, grant is inactive (`bgnt_n`=1), the drivers are enabled (`drv_en`=1) and `stall`=0. Reset is asynchronous and active low.
- R2: `breq_n` passes through SYNC_STAGES flops before it is used. A request first sampled low at clock edge k has no visible effect until edge k+SYNC_STAGES, and the outputs change at that edge.
- R3: If a request is seen while a cycle is running (`cyc_active`=1 and `cyc_end`=0), the grant asserts while `drv_en` stays 1.
- R4: While grant is asserted and the drivers are still enabled, a clock on which `cyc_end`=1 is followed by `drv_en`=0 after that edge.
- R5: If a request is seen with no cycle running (`cyc_active`=0), grant asserts and `drv_en` falls on the same edge.
- R6: If a request is seen on a cycle's final clock (`cyc_end`=1), grant and release happen together, with no pending phase.
- R7: Whenever grant is asserted or the drivers are disabled, `stall`=1.
- R8: After the synchronized request goes inactive, grant deasserts at the next edge while `drv_en` stays 0. One edge later `drv_en`=1 and `stall`=0.
- R9: A request withdrawn while grant is pending does not cancel the grant. The bus is still released at the cycle boundary and is then retaken through the R8 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| breq_n | input | 1 | Wired-OR bus request from other masters, active low, asynchronous |
| cyc_active | input | 1 | A bus cycle is in progress |
| cyc_end | input | 1 | Current clock is the last clock of the running cycle |
| bgnt_n | output | 1 | Bus grant to other masters, active low |
| drv_en | output | 1 | 1 = address, data and control drivers enabled; 0 = tri-stated |
| stall | output | 1 | Holds the cycle engine from starting a new cycle |

## Verification
Each result has a fixed latency, counted in clock edges:

| Stimulus | Result | Due after |
|---|---|---|
| Request edge on `breq_n` | Grant and release changes | SYNC_STAGES + 1 edges after the input is driven, that is one edge to sample it and SYNC_STAGES edges to reach the state register |
| `cyc_end` | Drivers float | the next edge |
| Request removal | Grant deasserts | the same synchronizer latency as a request |
| Grant deasserts | Drivers re-enabled | one further edge |

The bench drives inputs and reads outputs 1 ns after a rising edge, so every value it reads has already settled. It counts the edges explicitly before each read. At the edges just before each expected change it also checks that the outputs have not yet moved, so a result that is a cycle early or a cycle late fails.

// File: rtl/bga_pkg.sv
package bga_pkg;

   typedef enum logic [1:0] {
      ARB_OWN  = 2'd0,
      ARB_PEND = 2'd1,
      ARB_FREE = 2'd2,
      ARB_BACK = 2'd3
   } arb_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/bga_sync.sv
module bga_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_async,
   output logic req_seen
);
   localparam int unsigned LAST = STAGES - 1;

   logic [LAST:0] chain_q;

   generate
      if (STAGES < bga_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("bga_sync: STAGES below minimum");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= ~req_n_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign req_seen = chain_q[LAST];

endmodule

// File: rtl/bga_fsm.sv
module bga_fsm
   import bga_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_seen,
   input  logic       cyc_active,
   input  logic       cyc_end,
   output arb_state_e state
);
   arb_state_e state_q, state_d;
   logic       at_boundary;

   // The bus may change hands on the final clock of a cycle or when no cycle is in flight.
   assign at_boundary = cyc_end | ~cyc_active;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_OWN:  if (req_seen) state_d = at_boundary ? ARB_FREE : ARB_PEND;
         ARB_PEND: if (at_boundary) state_d = ARB_FREE;
         ARB_FREE: if (!req_seen) state_d = ARB_BACK;
         ARB_BACK: state_d = ARB_OWN;
         default:  state_d = ARB_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_OWN;
      else        state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/bga_decode.sv
module bga_decode
   import bga_pkg::*;
(
   input  arb_state_e state,
   output logic       bgnt_n,
   output logic       drv_en,
   output logic       stall
);
   always_comb begin
      bgnt_n = 1'b1;
      drv_en = 1'b1;
      stall  = 1'b1;
      unique case (state)
         ARB_OWN:  stall  = 1'b0;
         ARB_PEND: bgnt_n = 1'b0;
         ARB_FREE: begin
            bgnt_n = 1'b0;
            drv_en = 1'b0;
         end
         ARB_BACK: drv_en = 1'b0;
         default:  stall  = 1'b0;
      endcase
   end

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
   import bga_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic breq_n,
   input  logic cyc_active,
   input  logic cyc_end,
   output logic bgnt_n,
   output logic drv_en,
   output logic stall
);
   logic       req_seen;
   arb_state_e state;

   bga_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_n_async (breq_n),
      .req_seen    (req_seen)
   );

   bga_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_seen   (req_seen),
      .cyc_active (cyc_active),
      .cyc_end    (cyc_end),
      .state      (state)
   );

   bga_decode u_dec (
      .state  (state),
      .bgnt_n (bgnt_n),
      .drv_en (drv_en),
      .stall  (stall)
   );

endmodule

// File: rtl/bga_checker.sv
module bga_checker (
   input logic clk,
   input logic rst_n,
   input logic cyc_active,
   input logic cyc_end,
   input logic bgnt_n,
   input logic drv_en,
   input logic stall
);
   assert_grant_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bgnt_n |-> stall);

   assert_float_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |-> stall);

   assert_float_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bgnt_n && drv_en && cyc_end) |=> !drv_en);

   assert_pending_needs_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bgnt_n) && drv_en) |-> $past(cyc_active && !cyc_end));

   assert_retake_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bgnt_n) |-> !drv_en);

   assert_retake_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bgnt_n) |=> (drv_en && !stall));

endmodule

bind bus_grant_arbiter bga_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_active (cyc_active),
   .cyc_end    (cyc_end),
   .bgnt_n     (bgnt_n),
   .drv_en     (drv_en),
   .stall      (stall)
);

// File: tb/sim_bus_grant_arbiter.sv
`timescale 1ns/1ps
module sim_bus_grant_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int LAT        = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic breq_n = 1'b1;
   logic cyc_active = 1'b0;
   logic cyc_end = 1'b0;
   logic bgnt_n, drv_en, stall;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_grant_arbiter #(.SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .cyc_active(cyc_active),
      .cyc_end(cyc_end), .bgnt_n(bgnt_n), .drv_en(drv_en), .stall(stall)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect3(input string req, input logic g, input logic d, input logic s);
      n_chk++;
      if (bgnt_n !== g || drv_en !== d || stall !== s) begin
         n_bad++;
         $display("FAIL %s: got bgnt_n=%b drv_en=%b stall=%b, expected %b %b %b",
                  req, bgnt_n, drv_en, stall, g, d, s);
      end
   endtask

   // drop request and walk through the retake sequence from the released state
   task automatic withdraw_and_retake(input string req);
      breq_n = 1'b1;
      step(LAT - 1);
      expect3({req, " still released"}, 1'b0, 1'b0, 1'b1);
      step(1);
      expect3({req, " grant off first"}, 1'b1, 1'b0, 1'b1);
      step(1);
      expect3({req, " bus retaken"}, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #1;
      expect3("R1 during reset", 1'b1, 1'b1, 1'b0);
      step(2);
      rst_n = 1'b1;
      step(1);
      expect3("R1 after reset", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_idle();
      breq_n = 1'b0;
      step(LAT - 1);
      expect3("R2 not yet visible", 1'b1, 1'b1, 1'b0);
      step(1);
      expect3("R5 idle grant and release", 1'b0, 1'b0, 1'b1);
      withdraw_and_retake("R8");
   endtask

   task automatic t_mid_cycle();
      cyc_active = 1'b1;
      breq_n = 1'b0;
      step(LAT);
      expect3("R3 pending grant", 1'b0, 1'b1, 1'b1);
      step(3);
      expect3("R3 still pending", 1'b0, 1'b1, 1'b1);
      cyc_end = 1'b1;
      step(1);
      expect3("R4 float after end", 1'b0, 1'b0, 1'b1);
      cyc_end = 1'b0;
      cyc_active = 1'b0;
      withdraw_and_retake("R8 mid");
   endtask

   task automatic t_final_clock();
      cyc_active = 1'b1;
      breq_n = 1'b0;
      step(LAT - 1);
      cyc_end = 1'b1;
      step(1);
      expect3("R6 grant with release", 1'b0, 1'b0, 1'b1);
      cyc_end = 1'b0;
      cyc_active = 1'b0;
      withdraw_and_retake("R6");
   endtask

   task automatic t_withdraw_pending();
      cyc_active = 1'b1;
      breq_n = 1'b0;
      step(LAT);
      expect3("R9 pending", 1'b0, 1'b1, 1'b1);
      breq_n = 1'b1;
      step(LAT + 1);
      expect3("R9 grant kept", 1'b0, 1'b1, 1'b1);
      cyc_end = 1'b1;
      step(1);
      expect3("R9 released at boundary", 1'b0, 1'b0, 1'b1);
      cyc_end = 1'b0;
      cyc_active = 1'b0;
      step(1);
      expect3("R9 grant off", 1'b1, 1'b0, 1'b1);
      step(1);
      expect3("R9 retaken", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_reset_while_free();
      breq_n = 1'b0;
      step(LAT);
      expect3("R5 released", 1'b0, 1'b0, 1'b1);
      rst_n = 1'b0;
      #1;
      expect3("R1 reset clears grant", 1'b1, 1'b1, 1'b0);
      breq_n = 1'b1;
      step(1);
      rst_n = 1'b1;
      step(LAT + 1);
      expect3("R1 stays owned", 1'b1, 1'b1, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idle();
      t_mid_cycle();
      t_final_clock();
      t_withdraw_pending();
      t_reset_while_free();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule